// File: doc/BRIEF.md
# Variable-Width CRC and Pseudo-Random Sequence Slice

This block is an 8-bit shift-register slice. It either folds a serial bit stream into a cyclic redundancy check or runs as a free-running pseudo-random sequence generator, which is a Galois-form linear feedback shift register. A configuration value picks the top bit of the register, so the working width is anywhere from 2 to 8 bits. The feedback polynomial is a full register that the user programs. Each accepted step shifts the register by one place and applies the feedback in the same clock, so the engine handles one bit per cycle.

The serial input is a valid/ready stream of single bits. A bit is consumed on a clock edge where `step_valid_i` and `step_ready_o` are both high. The producer keeps `step_bit_i` steady until that edge. Ready goes low only in a cycle where a seed load is requested, because the load wins over the step in that cycle. With valid low, the register holds its value.

Two slices can be joined to form a 16-bit engine, and the same scheme extends to wider engines:
- The high slice computes the feedback bit and drives it out.
- The low slice uses that bit in place of its own top bit.
- The low slice's top bit shifts into bit 0 of the high slice.

Top module: `crc_prs_slice`

## Requirements
- R1: After reset the state reads 0, `lock_o` reads 0, and `step_ready_o` is 1 while `seed_ld_i` is 0.
- R2: When `seed_ld_i` is 1, the state on the next edge becomes `seed_i` masked to the selected width. Any step offered in that cycle is refused, because `step_ready_o` is 0 whenever `seed_ld_i` is 1.
- R3: A value m on `cfg_msb_i` selects bit m as the top bit, giving a width of m+1. The value 0 is treated as 1. State bits above the top bit always read 0, and polynomial bits above it have no effect.
- R4: In CRC mode (`cfg_mode_i`=0) with a standalone role, each accepted step computes f = `step_bit_i` XOR state[top]. It then shifts the state left with 0 entering bit 0, and XORs in the polynomial when f is 1. The result is masked to the width. With G = x^n + poly, seed S and k message bits M fed most significant bit first, the state becomes (S·x^k + M·x^n) mod G.
- R5: In PRS mode (`cfg_mode_i`=1), the feedback is state[top] alone and `step_bit_i` is ignored. After k steps from seed S, the state is S·x^k mod G.
- R6: Without an accepted step or a seed load, the state holds whatever `step_bit_i` does.
- R7: `ser_o` equals state[top]. `chain_fb_o` carries the slice's own feedback bit: in CRC mode state[top] XOR `step_bit_i`, in PRS mode state[top].
- R8: The two bits of `cfg_role_i` pick the role:
  - 00 or 11: standalone.
  - 01: low slice, which takes its feedback from `chain_fb_i`.
  - 10: high slice, which shifts `chain_sh_i` into bit 0.
  
  A low and a high slice, both with top bit 7, form a 16-bit engine that obeys R4 with n=16.
- R9: In PRS mode with a standalone role, an accepted step from an all-zero state keeps the state at zero and sets `lock_o`. `lock_o` then stays at 1 until a seed load clears it on that load's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 1 | 0 = CRC, 1 = PRS |
| cfg_role_i | input | 2 | 00/11 standalone, 01 low slice, 10 high slice |
| cfg_msb_i | input | MSBW (3) | Top bit index (0 is taken as 1) |
| cfg_poly_i | input | W (8) | Feedback polynomial without the x^n term |
| seed_ld_i | input | 1 | Load the seed on the next edge |
| seed_i | input | W (8) | Seed value |
| step_valid_i | input | 1 | Serial bit offered |
| step_ready_o | output | 1 | Serial bit can be taken this cycle |
| step_bit_i | input | 1 | Serial data bit |
| chain_fb_i | input | 1 | Feedback from the high neighbour (low role) |
| chain_sh_i | input | 1 | Shift-in bit from the low neighbour (high role) |
| state_o | output | W (8) | Register contents |
| ser_o | output | 1 | Top bit, serial output and shift-out to the neighbour |
| chain_fb_o | output | 1 | This slice's feedback bit, for the low neighbour |
| lock_o | output | 1 | Sticky all-zero PRS lockup flag |

## Verification
The assertions assume that mode, role, top bit and polynomial stay steady from a seed load through the steps that follow it. They also assume that the lockup property applies only to the standalone role, since a zero slice in a chain is not a lockup. The bench changes configuration only in the same cycle as a seed load and runs chained tests with both slices configured together. Expected register values come from polynomial long division in the bench. The polynomial is driven with junk above the top bit, so the masking is exercised.

// File: rtl/crc_prs_pkg.sv
package crc_prs_pkg;

  typedef enum logic {
    MODE_CRC = 1'b0,
    MODE_PRS = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    ROLE_ALONE = 2'b00,
    ROLE_LOW   = 2'b01,
    ROLE_HIGH  = 2'b10,
    ROLE_ALT   = 2'b11
  } role_e;

  function automatic logic role_is_alone(input role_e r);
    return (r == ROLE_ALONE) || (r == ROLE_ALT);
  endfunction

endpackage

// File: rtl/crc_prs_mask.sv
module crc_prs_mask #(
  parameter int W    = 8,
  parameter int MSBW = $clog2(W)
) (
  input  logic [MSBW-1:0] msb_i,
  output logic [MSBW-1:0] msb_eff_o,
  output logic [W-1:0]    mask_o
);

  // Narrowest legal register is two bits; clamp the top index into range.
  always_comb begin
    if (msb_i == '0)
      msb_eff_o = MSBW'(1);
    else if (int'(msb_i) > W - 1)
      msb_eff_o = MSBW'(W - 1);
    else
      msb_eff_o = msb_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask_o[i] = (int'(msb_eff_o) >= i);
  end

endmodule

// File: rtl/crc_prs_tap.sv
module crc_prs_tap
  import crc_prs_pkg::*;
#(
  parameter int W    = 8,
  parameter int MSBW = $clog2(W)
) (
  input  logic [W-1:0]    state_i,
  input  logic [MSBW-1:0] msb_eff_i,
  input  mode_e           mode_i,
  input  role_e           role_i,
  input  logic            din_i,
  input  logic            chain_fb_i,
  output logic            top_bit_o,
  output logic            fb_local_o,
  output logic            fb_o
);

  always_comb begin
    top_bit_o  = state_i[msb_eff_i];
    fb_local_o = (mode_i == MODE_PRS) ? top_bit_o : (top_bit_o ^ din_i);
    // A low slice borrows the decision made at the real top of the chain.
    fb_o       = (role_i == ROLE_LOW) ? chain_fb_i : fb_local_o;
  end

endmodule

// File: rtl/crc_prs_next.sv
module crc_prs_next
  import crc_prs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] poly_i,
  input  logic [W-1:0] mask_i,
  input  logic         fb_i,
  input  role_e        role_i,
  input  logic         chain_sh_i,
  output logic [W-1:0] next_o
);

  logic         shin;
  logic [W-1:0] shifted;
  logic [W-1:0] taps;

  always_comb begin
    shin    = (role_i == ROLE_HIGH) ? chain_sh_i : 1'b0;
    shifted = {state_i[W-2:0], shin};
    taps    = poly_i & {W{fb_i}};
    next_o  = (shifted ^ taps) & mask_i;
  end

endmodule

// File: rtl/crc_prs_lock.sv
module crc_prs_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic arm_i,
  output logic lock_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      lock_o <= 1'b0;
    else if (clear_i)
      lock_o <= 1'b0;
    else if (arm_i)
      lock_o <= 1'b1;
  end

endmodule

// File: rtl/crc_prs_slice.sv
module crc_prs_slice
  import crc_prs_pkg::*;
#(
  parameter int W    = 8,
  parameter int MSBW = $clog2(W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_mode_i,
  input  logic [1:0]      cfg_role_i,
  input  logic [MSBW-1:0] cfg_msb_i,
  input  logic [W-1:0]    cfg_poly_i,
  input  logic            seed_ld_i,
  input  logic [W-1:0]    seed_i,
  input  logic            step_valid_i,
  output logic            step_ready_o,
  input  logic            step_bit_i,
  input  logic            chain_fb_i,
  input  logic            chain_sh_i,
  output logic [W-1:0]    state_o,
  output logic            ser_o,
  output logic            chain_fb_o,
  output logic            lock_o
);

  mode_e           mode;
  role_e           role;
  logic [MSBW-1:0] msb_eff;
  logic [W-1:0]    mask;
  logic [W-1:0]    state_q;
  logic [W-1:0]    state_d;
  logic            top_bit;
  logic            fb_local;
  logic            fb;
  logic            accept;
  logic            lock_arm;

  assign mode = mode_e'(cfg_mode_i);
  assign role = role_e'(cfg_role_i);

  assign step_ready_o = ~seed_ld_i;
  assign accept       = step_valid_i & step_ready_o;

  crc_prs_mask #(.W(W), .MSBW(MSBW)) u_mask (
    .msb_i     (cfg_msb_i),
    .msb_eff_o (msb_eff),
    .mask_o    (mask)
  );

  crc_prs_tap #(.W(W), .MSBW(MSBW)) u_tap (
    .state_i    (state_q),
    .msb_eff_i  (msb_eff),
    .mode_i     (mode),
    .role_i     (role),
    .din_i      (step_bit_i),
    .chain_fb_i (chain_fb_i),
    .top_bit_o  (top_bit),
    .fb_local_o (fb_local),
    .fb_o       (fb)
  );

  crc_prs_next #(.W(W)) u_next (
    .state_i    (state_q),
    .poly_i     (cfg_poly_i),
    .mask_i     (mask),
    .fb_i       (fb),
    .role_i     (role),
    .chain_sh_i (chain_sh_i),
    .next_o     (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      state_q <= '0;
    else if (seed_ld_i)
      state_q <= seed_i & mask;
    else if (accept)
      state_q <= state_d;
  end

  assign lock_arm = accept && (mode == MODE_PRS) && role_is_alone(role)
                    && ((state_q & mask) == '0);

  crc_prs_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (seed_ld_i),
    .arm_i   (lock_arm),
    .lock_o  (lock_o)
  );

  assign state_o    = state_q;
  assign ser_o      = top_bit;
  assign chain_fb_o = fb_local;

endmodule

// File: rtl/crc_prs_slice_chk.sv
module crc_prs_slice_chk #(
  parameter int W    = 8,
  parameter int MSBW = $clog2(W)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_mode_i,
  input logic [1:0]      cfg_role_i,
  input logic [MSBW-1:0] cfg_msb_i,
  input logic            seed_ld_i,
  input logic [W-1:0]    seed_i,
  input logic            step_valid_i,
  input logic            step_ready_o,
  input logic [W-1:0]    state_o,
  input logic            ser_o,
  input logic            chain_fb_o,
  input logic            lock_o
);

  logic [W-1:0] chk_mask;
  logic         alone;

  always_comb begin
    int top;
    top = (cfg_msb_i == '0) ? 1 : int'(cfg_msb_i);
    if (top > W - 1) top = W - 1;
    for (int i = 0; i < W; i++) chk_mask[i] = (i <= top);
  end

  assign alone = (cfg_role_i == 2'b00) || (cfg_role_i == 2'b11);

  AST_LOAD_REFUSES_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_ld_i |-> !step_ready_o); // R2

  AST_SEED_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_ld_i |=> state_o == ($past(seed_i) & $past(chk_mask))); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_ld_i || (step_valid_i && step_ready_o)) |=> (state_o & ~$past(chk_mask)) == '0); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_ld_i && !step_valid_i) |=> $stable(state_o)); // R6

  AST_PRS_FB_IS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i |-> chain_fb_o == ser_o); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !seed_ld_i) |=> lock_o); // R9

  AST_LOCK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_ld_i |=> !lock_o); // R9

  AST_PRS_ZERO_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_ld_i && step_valid_i && cfg_mode_i && alone && state_o == '0)
      |=> (state_o == '0) && lock_o); // R9

endmodule

bind crc_prs_slice crc_prs_slice_chk #(.W(W), .MSBW(MSBW)) u_chk (.*);

// File: tb/crc_prs_slice_bench.sv
`timescale 1ns/100ps
module crc_prs_slice_bench;

  localparam int W    = 8;
  localparam int MSBW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // shared controls
  logic seed_ld = 1'b0, step_valid = 1'b0, mode = 1'b0;
  // slice A (standalone or low), slice B (high)
  logic [1:0]      a_role = 2'b00, b_role = 2'b10;
  logic [MSBW-1:0] a_msb = 3'd7, b_msb = 3'd7;
  logic [W-1:0]    a_poly = '0, b_poly = '0, a_seed = '0, b_seed = '0;
  logic            a_bit = 1'b0, b_bit = 1'b0;
  logic [W-1:0]    a_state, b_state;
  logic            a_ready, b_ready, a_ser, b_ser, a_fbo, b_fbo, a_lock, b_lock;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  crc_prs_slice #(.W(W), .MSBW(MSBW)) u_crc_prs_slice (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode), .cfg_role_i(a_role),
    .cfg_msb_i(a_msb), .cfg_poly_i(a_poly), .seed_ld_i(seed_ld), .seed_i(a_seed),
    .step_valid_i(step_valid), .step_ready_o(a_ready), .step_bit_i(a_bit),
    .chain_fb_i(b_fbo), .chain_sh_i(1'b0), .state_o(a_state), .ser_o(a_ser),
    .chain_fb_o(a_fbo), .lock_o(a_lock));

  crc_prs_slice #(.W(W), .MSBW(MSBW)) u_crc_prs_slice_hi (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode), .cfg_role_i(b_role),
    .cfg_msb_i(b_msb), .cfg_poly_i(b_poly), .seed_ld_i(seed_ld), .seed_i(b_seed),
    .step_valid_i(step_valid), .step_ready_o(b_ready), .step_bit_i(b_bit),
    .chain_fb_i(1'b0), .chain_sh_i(a_ser), .state_o(b_state), .ser_o(b_ser),
    .chain_fb_o(b_fbo), .lock_o(b_lock));

  task automatic next_rand(output logic [31:0] r);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    r = lcg;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // remainder of v modulo x^n + p over GF(2)
  function automatic longint unsigned ref_rem(input longint unsigned v, input int n,
                                              input longint unsigned p);
    longint unsigned g;
    g = (64'd1 << n) | p;
    for (int i = 63; i >= n; i--)
      if (v[i]) v = v ^ (g << (i - n));
    return v;
  endfunction

  task automatic load_a(input logic [W-1:0] seed);
    a_seed = seed; seed_ld = 1'b1;
    cycle();
    seed_ld = 1'b0;
  endtask

  // standalone run on slice A: R4 for CRC, R5 for PRS (message still driven, must be ignored)
  task automatic run_one(input int n, input logic [W-1:0] poly_raw, input logic [W-1:0] seed_raw,
                         input longint unsigned msg, input int k, input logic prs, input string tag);
    longint unsigned lm, exp;
    a_role = 2'b00; a_msb = 3'(n - 1); mode = prs; a_poly = poly_raw;
    load_a(seed_raw);
    for (int j = k - 1; j >= 0; j--) begin
      a_bit = msg[j]; step_valid = 1'b1;
      cycle();
    end
    step_valid = 1'b0;
    lm  = (64'd1 << n) - 1;
    exp = ref_rem(((64'(seed_raw) & lm) << k) ^ (prs ? 64'd0 : (msg << n)), n, 64'(poly_raw) & lm);
    chk(tag, 64'(a_state), exp);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 state", 64'(a_state), 0);
    chk("R1 lock", 64'(a_lock), 0);
    chk("R1 ready", 64'(a_ready), 1);

    // R3 width select and clamp of 0
    a_msb = 3'd0; load_a(8'hFF);
    chk("R3 msb0 width2", 64'(a_state), 64'h03);
    a_msb = 3'd5; load_a(8'hFF);
    chk("R3 msb5 width6", 64'(a_state), 64'h3F);

    // R2 load beats a step in the same cycle
    a_msb = 3'd7; mode = 1'b0; a_poly = 8'h07;
    a_seed = 8'hC3; seed_ld = 1'b1; step_valid = 1'b1; a_bit = 1'b1;
    #1 chk("R2 ready low", 64'(a_ready), 0);
    cycle();
    seed_ld = 1'b0; step_valid = 1'b0;
    chk("R2 seed wins", 64'(a_state), 64'hC3);

    // R6 hold without valid
    load_a(8'h5A);
    for (int i = 0; i < 5; i++) begin a_bit = ~a_bit; cycle(); end
    chk("R6 hold", 64'(a_state), 64'h5A);

    // R7 serial out and exported feedback (bit 3 is the top at msb 3)
    a_msb = 3'd3; load_a(8'h08);
    chk("R7 ser one", 64'(a_ser), 1);
    a_bit = 1'b1; #1 chk("R7 fb crc 1^1", 64'(a_fbo), 0);
    a_bit = 1'b0; #1 chk("R7 fb crc 1^0", 64'(a_fbo), 1);
    load_a(8'h07);
    chk("R7 ser zero", 64'(a_ser), 0);

    // R9 PRS lockup
    mode = 1'b1; a_msb = 3'd7; a_poly = 8'h1D; a_role = 2'b00;
    load_a(8'h00);
    step_valid = 1'b1; cycle(); step_valid = 1'b0;
    chk("R9 zero stays", 64'(a_state), 0);
    chk("R9 lock set", 64'(a_lock), 1);
    cycle(); cycle();
    chk("R9 lock sticky", 64'(a_lock), 1);
    load_a(8'h01);
    chk("R9 lock cleared", 64'(a_lock), 0);

    // R4 exhaustive 3-bit CRC: every poly, seed and 6-bit message
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 64; m++)
          run_one(3, 8'(p) | 8'hA8, 8'(s) | 8'h50, 64'(m), 6, 1'b0, "R4 crc3");

    // R4 and R5 across widths 2..8
    for (int n = 2; n <= 8; n++)
      for (int c = 0; c < 24; c++) begin
        logic [31:0] q;
        next_rand(r); next_rand(q);
        run_one(n, r[7:0], r[15:8], 64'(q[15:0]), 16, 1'b0, "R4 crc width");
        run_one(n, r[23:16], r[31:24], 64'(q[31:16]), 20, 1'b1, "R5 prs width");
      end

    // R8 two chained slices form a 16-bit CRC
    for (int c = 0; c < 12; c++) begin
      logic [15:0] poly16, seed16, msg16;
      longint unsigned exp;
      next_rand(r); poly16 = (c == 0) ? 16'h1021 : r[15:0]; seed16 = r[31:16];
      next_rand(r); msg16 = r[15:0];
      mode = 1'b0; a_role = 2'b01; b_role = 2'b10; a_msb = 3'd7; b_msb = 3'd7;
      a_poly = poly16[7:0]; b_poly = poly16[15:8];
      a_seed = seed16[7:0]; b_seed = seed16[15:8];
      seed_ld = 1'b1; cycle(); seed_ld = 1'b0;
      for (int j = 15; j >= 0; j--) begin
        b_bit = msg16[j]; a_bit = r[16 + j]; step_valid = 1'b1;
        cycle();
      end
      step_valid = 1'b0;
      exp = ref_rem((64'(seed16) << 16) ^ (64'(msg16) << 16), 16, 64'(poly16));
      chk("R8 chained crc16", 64'({b_state, a_state}), exp);
    end
    a_role = 2'b00;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule